// File: doc/BRIEF.md
# Flash Erase Command Interface

This block decodes erase commands from an 8-bit host bus and drives the erase of a small register-based flash array model. An erase takes two bus writes: the erase opcode 0x20, then a confirm byte. A confirm of 0x20 erases every block. A confirm of 0xD0 erases only the block named by the upper address bits of that second write. Each erase runs a fixed-length timed phase, which sets the target bytes to 0xFF. A verify phase follows, which reads every target byte back and records any byte that is not 0xFF as an error.

The host reads one data bus. That bus returns either array bytes or the status byte. When an erase starts, or when a confirm byte is rejected, the bus switches to status by itself. It stays on status until the host writes 0xFF. A ready output mirrors the busy bit of the status byte. A fault input lets a test corrupt the erase so that the error path can be exercised.

States of the sequencer:
- ST_IDLE waits for a first byte. On 0x20 it goes to ST_CONFIRM.
- ST_CONFIRM waits for the second byte. A valid confirm goes to ST_ERASE. Any other byte goes back to ST_IDLE.
- ST_ERASE counts ERASE_CYCLES clocks. It then goes to ST_VERIFY.
- ST_VERIFY scans one byte per clock. After the last target byte it goes to ST_IDLE.

Top module: `flash_erase_ctl`

## Requirements
- R1: After reset the bus reads array data, `ready_o` is 1 and the erase-error flag is clear. Array byte i resets to i XOR 0x5A.
- R2: Writing 0x20 and then 0x20 sets every array byte to 0xFF. `ready_o` is low for ERASE_CYCLES + (total bytes) cycles.
- R3: Writing 0x20 and then 0xD0 erases only block `bus_addr >> log2(BLOCK_BYTES)` of the confirm write. The other blocks are unchanged. `ready_o` is low for ERASE_CYCLES + BLOCK_BYTES cycles.
- R4: `ready_o` is the busy bit (status bit 7). It is 0 from the clock after the confirm write until the operation completes.
- R5: In status mode the bus returns {busy_n, 0, err, 00000}, where bit 7 is not-busy and bit 5 is error. Status mode begins when an erase starts and persists after completion, for every address.
- R6: Writing 0xFF while idle returns the bus to array data. Other first bytes written while idle have no effect.
- R7: A second byte after 0x20 that is neither 0x20 nor 0xD0 sets the error bit and enters status mode. It leaves the array unchanged, starts nothing and returns to ST_IDLE.
- R8: While busy, all command writes are ignored. A 0xFF write does not leave status mode, and a full erase sequence does not start a second erase.
- R9: If `fault_inject` is high when the timed phase ends, the first byte of the target range stays 0xFE. The error bit reads 1 after completion.
- R10: Starting an erase clears the error bit. A clean erase after a failed one reports status 0x80.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Host write strobe, one cycle per write |
| bus_addr | input | ADDR_W | Host address for array reads and the block-erase confirm |
| bus_wdata | input | 8 | Command byte |
| bus_rdata | output | 8 | Array byte or status byte |
| ready_o | output | 1 | 1 when idle, 0 while an erase runs |
| fault_inject | input | 1 | Test input: corrupts the first target byte at the end of the erase |

## Verification
The bench counts exactly how many cycles `ready_o` stays low for each kind of erase. A counter that is off by one would show up as a wrong busy length. So would a verify scan that covered the wrong range. Block-erase tests check every byte of the neighbouring blocks, which catches a block number decoded from the wrong address bits. The bench writes 0xFF and a second erase sequence while busy, so a design that let either through would leave status mode early or stay busy for too long. Bad confirm bytes and fault-injected erases are mixed with clean ones, so an error bit that never sets, or one that is never cleared, is reported.

// File: rtl/fe_pkg.sv
package fe_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CONFIRM,
        ST_ERASE,
        ST_VERIFY
    } fe_state_e;

    localparam logic [7:0] CMD_ERASE      = 8'h20;
    localparam logic [7:0] CMD_BLOCK_CONF = 8'hD0;
    localparam logic [7:0] CMD_READ_ARRAY = 8'hFF;
    localparam logic [7:0] ERASED_BYTE    = 8'hFF;
    localparam logic [7:0] FAULT_BYTE     = 8'hFE;
endpackage

// File: rtl/fe_array.sv
module fe_array
    import fe_pkg::*;
#(
    parameter int DEPTH  = 64,
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    input  logic [ADDR_W-1:0] chk_addr,
    output logic [7:0]        chk_data,
    input  logic              ers_en,
    input  logic [ADDR_W-1:0] ers_lo,
    input  logic [ADDR_W-1:0] ers_hi,
    input  logic              ers_fault
);
    logic [7:0] mem [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_cell
        localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(g);
        logic [7:0] cell_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cell_q <= 8'(g) ^ 8'h5A;
            end else if (ers_en && MY_ADDR >= ers_lo && MY_ADDR <= ers_hi) begin
                cell_q <= (ers_fault && MY_ADDR == ers_lo) ? FAULT_BYTE : ERASED_BYTE;
            end
        end
        assign mem[g] = cell_q;
    end

    assign rd_data  = mem[rd_addr];
    assign chk_data = mem[chk_addr];
endmodule

// File: rtl/fe_seq.sv
module fe_seq
    import fe_pkg::*;
#(
    parameter int NUM_BLOCKS   = 4,
    parameter int BLOCK_BYTES  = 16,
    parameter int ERASE_CYCLES = 40,
    parameter int ADDR_W       = 6
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cmd_we,
    input  logic [7:0]                    cmd_data,
    input  logic [$clog2(NUM_BLOCKS)-1:0] cmd_blk,
    input  logic [7:0]                    chk_data,
    output logic                          ers_en,
    output logic [ADDR_W-1:0]             ers_lo,
    output logic [ADDR_W-1:0]             ers_hi,
    output logic [ADDR_W-1:0]             chk_addr,
    output logic                          sr7,
    output logic                          sr5,
    output logic                          rd_status,
    output fe_state_e                     state_o
);
    localparam int DEPTH = NUM_BLOCKS * BLOCK_BYTES;
    localparam int OW    = $clog2(BLOCK_BYTES);
    localparam int CW    = $clog2(ERASE_CYCLES + 1);

    fe_state_e         state_q, state_d;
    logic [CW-1:0]     cnt_q;
    logic [ADDR_W-1:0] lo_q, hi_q, chk_q;
    logic              conf_ok, start, reject, erase_done, scan_done;

    assign conf_ok    = (cmd_data == CMD_ERASE) || (cmd_data == CMD_BLOCK_CONF);
    assign start      = (state_q == ST_CONFIRM) && cmd_we && conf_ok;
    assign reject     = (state_q == ST_CONFIRM) && cmd_we && !conf_ok;
    assign erase_done = (state_q == ST_ERASE) && (cnt_q == CW'(ERASE_CYCLES - 1));
    assign scan_done  = (state_q == ST_VERIFY) && (chk_q == hi_q);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (cmd_we && cmd_data == CMD_ERASE) state_d = ST_CONFIRM;
            ST_CONFIRM: if (cmd_we) state_d = conf_ok ? ST_ERASE : ST_IDLE;
            ST_ERASE:   if (erase_done) state_d = ST_VERIFY;
            ST_VERIFY:  if (scan_done) state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // outputs and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            lo_q      <= '0;
            hi_q      <= '0;
            chk_q     <= '0;
            sr7       <= 1'b1;
            sr5       <= 1'b0;
            rd_status <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (cmd_we && cmd_data == CMD_READ_ARRAY) rd_status <= 1'b0;
                end
                ST_CONFIRM: begin
                    if (start) begin
                        cnt_q     <= '0;
                        sr7       <= 1'b0;
                        sr5       <= 1'b0;
                        rd_status <= 1'b1;
                        if (cmd_data == CMD_ERASE) begin
                            lo_q <= '0;
                            hi_q <= ADDR_W'(DEPTH - 1);
                        end else begin
                            lo_q <= {cmd_blk, {OW{1'b0}}};
                            hi_q <= {cmd_blk, {OW{1'b1}}};
                        end
                    end else if (reject) begin
                        sr5       <= 1'b1;
                        rd_status <= 1'b1;
                    end
                end
                ST_ERASE: begin
                    cnt_q <= cnt_q + 1'b1;
                    if (erase_done) chk_q <= lo_q;
                end
                ST_VERIFY: begin
                    if (chk_data != ERASED_BYTE) sr5 <= 1'b1;
                    if (scan_done) sr7 <= 1'b1;
                    else           chk_q <= chk_q + 1'b1;
                end
                default: ;
            endcase
        end
    end

    assign ers_en   = erase_done;
    assign ers_lo   = lo_q;
    assign ers_hi   = hi_q;
    assign chk_addr = chk_q;
    assign state_o  = state_q;
endmodule

// File: rtl/flash_erase_ctl.sv
module flash_erase_ctl
    import fe_pkg::*;
#(
    parameter int NUM_BLOCKS   = 4,
    parameter int BLOCK_BYTES  = 16,
    parameter int ERASE_CYCLES = 40,
    parameter int ADDR_W       = $clog2(NUM_BLOCKS * BLOCK_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic              ready_o,
    input  logic              fault_inject
);
    localparam int DEPTH = NUM_BLOCKS * BLOCK_BYTES;
    localparam int OW    = $clog2(BLOCK_BYTES);

    logic              ers_en, sr7, sr5, rd_status;
    logic [ADDR_W-1:0] ers_lo, ers_hi, chk_addr;
    logic [7:0]        arr_rdata, chk_data, status_byte;
    fe_state_e         seq_state;

    fe_seq #(
        .NUM_BLOCKS  (NUM_BLOCKS),
        .BLOCK_BYTES (BLOCK_BYTES),
        .ERASE_CYCLES(ERASE_CYCLES),
        .ADDR_W      (ADDR_W)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_we   (bus_we),
        .cmd_data (bus_wdata),
        .cmd_blk  (bus_addr[ADDR_W-1:OW]),
        .chk_data (chk_data),
        .ers_en   (ers_en),
        .ers_lo   (ers_lo),
        .ers_hi   (ers_hi),
        .chk_addr (chk_addr),
        .sr7      (sr7),
        .sr5      (sr5),
        .rd_status(rd_status),
        .state_o  (seq_state)
    );

    fe_array #(
        .DEPTH (DEPTH),
        .ADDR_W(ADDR_W)
    ) u_array (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_addr  (bus_addr),
        .rd_data  (arr_rdata),
        .chk_addr (chk_addr),
        .chk_data (chk_data),
        .ers_en   (ers_en),
        .ers_lo   (ers_lo),
        .ers_hi   (ers_hi),
        .ers_fault(fault_inject)
    );

    assign status_byte = {sr7, 1'b0, sr5, 5'b0};
    assign bus_rdata   = rd_status ? status_byte : arr_rdata;
    assign ready_o     = sr7;
endmodule

// File: rtl/fe_chk.sv
module fe_chk
    import fe_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       we,
    input logic [7:0] wdata,
    input logic [7:0] rdata,
    input logic       ready,
    input logic       rd_status,
    input logic       sr5,
    input fe_state_e  state
);
    // R5
    status_bit7_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_status |-> (rdata[7] == ready));

    // R4
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CONFIRM && we && (wdata == CMD_ERASE || wdata == CMD_BLOCK_CONF))
        |=> (!ready && rd_status && state == ST_ERASE));

    // R8
    busy_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ERASE || state == ST_VERIFY) |-> !ready);

    // R8
    busy_hold_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready && rd_status) |=> rd_status);

    // R7
    reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CONFIRM && we && wdata != CMD_ERASE && wdata != CMD_BLOCK_CONF)
        |=> (sr5 && ready && rd_status && state == ST_IDLE));

    // R6
    read_array_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && we && wdata == CMD_READ_ARRAY) |=> !rd_status);
endmodule

bind flash_erase_ctl fe_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (bus_we),
    .wdata    (bus_wdata),
    .rdata    (bus_rdata),
    .ready    (ready_o),
    .rd_status(rd_status),
    .sr5      (sr5),
    .state    (seq_state)
);

// File: tb/flash_erase_ctl_tb.sv
module flash_erase_ctl_tb;
    localparam int NB    = 4;
    localparam int BB    = 16;
    localparam int EC    = 40;
    localparam int DEPTH = NB * BB;
    localparam int AW    = $clog2(DEPTH);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          we = 1'b0;
    logic          fault = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [7:0]    wdata = '0;
    logic [7:0]    rdata;
    logic          ready;

    int   checks = 0;
    int   fails  = 0;
    bit   done   = 1'b0;
    logic [7:0] model [DEPTH];

    always #4 clk = ~clk;

    flash_erase_ctl #(
        .NUM_BLOCKS(NB), .BLOCK_BYTES(BB), .ERASE_CYCLES(EC)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_we(we), .bus_addr(addr),
        .bus_wdata(wdata), .bus_rdata(rdata), .ready_o(ready),
        .fault_inject(fault)
    );

    function automatic logic [7:0] stat_exp(bit err);
        return {1'b1, 1'b0, err, 5'b0};
    endfunction

    function automatic int busy_exp(bit all);
        return EC + (all ? DEPTH : BB);
    endfunction

    task automatic check(string req, int act, int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(int a, logic [7:0] d);
        @(negedge clk);
        addr = AW'(a); wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        for (int i = 0; i < DEPTH; i++) model[i] = 8'(i) ^ 8'h5A;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 ready after reset", int'(ready), 1);
        addr = AW'(DEPTH - 1); #1;
        check("R1 array mode after reset", int'(rdata), int'(model[DEPTH-1]));
    endtask

    task automatic wait_ready(output int cnt);
        cnt = 0;
        while (!ready && cnt < 100000) begin
            cnt++;
            @(negedge clk);
        end
    endtask

    task automatic apply_model(bit all, int blk, bit flt);
        int lo = all ? 0 : blk * BB;
        int n  = all ? DEPTH : BB;
        for (int i = lo; i < lo + n; i++) model[i] = 8'hFF;
        if (flt) model[lo] = 8'hFE;
    endtask

    task automatic check_array(string req);
        wr(0, 8'hFF);
        for (int i = 0; i < DEPTH; i++) begin
            addr = AW'(i); #1;
            check(req, int'(rdata), int'(model[i]));
        end
    endtask

    task automatic run_erase(bit all, int blk, bit flt, string req);
        int cnt;
        wr(0, 8'h20);
        fault = flt;
        wr(blk * BB, all ? 8'h20 : 8'hD0);
        check({req, " R4 busy after confirm"}, int'(ready), 0);
        wait_ready(cnt);
        fault = 1'b0;
        check({req, " busy length"}, cnt, busy_exp(all));
        check({"R5/R9/R10 status ", req}, int'(rdata), int'(stat_exp(flt)));
        apply_model(all, blk, flt);
    endtask

    initial begin
        int cnt;
        int seed_val;
        seed_val = $urandom(32'd20240607);
        do_reset();

        // R6: unknown idle byte is ignored, FF in array mode keeps array reads
        wr(0, 8'h55);
        addr = AW'(3); #1;
        check("R6 idle junk ignored", int'(rdata), int'(model[3]));

        // R3: block erase of block 2
        run_erase(1'b0, 2, 1'b0, "R3");
        // R5: status persists and is address independent
        repeat (5) @(negedge clk);
        addr = AW'(5); #1;
        check("R5 status persists", int'(rdata), int'(stat_exp(1'b0)));
        check_array("R3 R6 array after block erase");

        // R2 + R9: erase all with fault
        run_erase(1'b1, 0, 1'b1, "R2 R9");
        check_array("R2 R9 array after faulty erase all");

        // R10: clean erase clears the error bit
        run_erase(1'b0, 0, 1'b0, "R10");
        check_array("R10 array");

        // R7: bad confirm byte
        do_reset();
        wr(0, 8'h20);
        wr(0, 8'h55);
        check("R7 not busy after reject", int'(ready), 1);
        addr = AW'(9); #1;
        check("R7 error status", int'(rdata), int'(stat_exp(1'b1)));
        check_array("R7 array untouched");

        // R8: writes while busy are ignored
        wr(0, 8'h20);
        wr(3 * BB, 8'hD0);
        wr(0, 8'hFF);
        wr(0, 8'h20);
        wr(0, 8'hD0);
        wait_ready(cnt);
        check("R8 busy length unchanged", cnt, busy_exp(1'b0) - 6);
        check("R8 still status mode", int'(rdata), int'(stat_exp(1'b0)));
        repeat (3) @(negedge clk);
        check("R8 no second erase", int'(ready), 1);
        apply_model(1'b0, 3, 1'b0);
        check_array("R8 array");

        // random mix
        for (int it = 0; it < 12; it++) begin
            bit all = ($urandom % 4) == 0;
            int blk = int'($urandom % NB);
            bit flt = ($urandom % 3) == 0;
            if ((it % 3) == 0) do_reset();
            if (($urandom % 4) == 0) begin
                wr(0, 8'h20);
                wr(0, 8'h11);
                addr = AW'($urandom); #1;
                check("R7 random reject", int'(rdata), int'(stat_exp(1'b1)));
            end
            run_erase(all, blk, flt, all ? "R2 random" : "R3 random");
            check_array("R2 R3 random array");
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule